// File: doc/BRIEF.md
# External Event Timestamp Capture

This block records the precise time at which an external signal changes level. One of up to 64 candidate input pins is picked by a selector. Its level is resynchronised into the local clock domain and watched for an edge of the programmed polarity. When such an edge is detected, the block latches the live seconds and nanoseconds values from the time counter into a single 64-bit capture word. Seconds go in the upper half and nanoseconds in the lower half.

A valid flag tells software that a fresh capture is waiting. A read strobe from the register port consumes it. If a second edge arrives before software has read the first, the newer time replaces the older one and an overflow flag records the loss. While capture is disabled, edges have no effect. After a change of the selector, the block blanks detection until the synchroniser has flushed, so that switching pins does not itself look like an edge.

Top module: `ext_event_stamp`

## Requirements
- R1: While reset is asserted, and after it until the first capture, `stamp_o` is 0 and `valid_o` and `ovf_o` are 0.
- R2: With `cap_en_i`=1 and `edge_fall_i`=0, a rising edge on the selected pin sets `valid_o` and loads `stamp_o`. The value loaded is the time presented during the cycle before the clock edge that lies SYNC_STAGES edges after the first clock edge at which the pin shows its new level.
- R3: With `edge_fall_i`=1 a falling edge of the selected pin captures and a rising edge does not. With `edge_fall_i`=0 a falling edge does not capture.
- R4: The capture word holds seconds in bits 63:32 and nanoseconds in bits 31:0.
- R5: `sel_i` (6 bits, value n picks `pins_i[n]`) chooses the only pin whose edges can capture. Edges on all other pins are ignored.
- R6: A cycle with `rd_i`=1 and no capture clears `valid_o` and `ovf_o` from the next cycle on, and leaves `stamp_o` unchanged.
- R7: An edge captured while `valid_o`=1 and `rd_i`=0 overwrites `stamp_o` with the newer time and sets `ovf_o`. `ovf_o` is never 1 while `valid_o` is 0.
- R8: While `cap_en_i`=0, edges are ignored: `stamp_o`, `valid_o` and `ovf_o` keep their values.
- R9: A change of `sel_i` between pins at different levels causes no capture. Detection is blanked for SYNC_STAGES cycles after the change, and later edges on the new pin capture normally.
- R10: A selected pin that is already high when reset is released causes no capture.
- R11: When a capture and `rd_i`=1 fall in the same cycle, the new time is stored, `valid_o` stays 1 and `ovf_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_i | input | SEC_W | Live seconds value from the time counter |
| nsec_i | input | NS_W | Live nanoseconds value from the time counter |
| pins_i | input | NUM_PINS | Candidate external event inputs, asynchronous |
| cap_en_i | input | 1 | Capture enable |
| edge_fall_i | input | 1 | Edge polarity: 0 rising, 1 falling |
| sel_i | input | $clog2(NUM_PINS) | Index of the pin to watch |
| rd_i | input | 1 | Software read strobe of the capture word |
| stamp_o | output | SEC_W+NS_W | Captured time: seconds in the upper half, nanoseconds in the lower half |
| valid_o | output | 1 | An unread capture is held |
| ovf_o | output | 1 | A capture overwrote an unread one |

## Verification
The bench builds the block with the full 64-pin bank and a three-stage synchroniser. With 64 pins, both selector extremes 0 and 63 can be exercised next to a neighbouring pin that must be ignored. With three stages, the capture latency and the blanking window are counted from the parameter rather than from a fixed two-flop chain. The time source starts just below a seconds rollover, so the seconds and nanoseconds fields are checked across a carry, and same-cycle read and capture is aimed at exactly.

// File: rtl/evs_pkg.sv
package evs_pkg;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_pol_e;

endpackage

// File: rtl/evs_pin_mux.sv
module evs_pin_mux #(
    parameter int NUM_PINS = 64,
    parameter int SEL_W    = 6
) (
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [SEL_W-1:0]    sel_i,
    output logic                pin_o
);

    // Selector values beyond the pin count read as a quiet low input.
    always_comb begin
        pin_o = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (sel_i == SEL_W'(i)) begin
                pin_o = pins_i[i];
            end
        end
    end

endmodule

// File: rtl/evs_sync_edge.sv
module evs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din_i,
    input  logic rearm_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int CNT_W = $clog2(STAGES + 2);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
        logic [CNT_W-1:0]  blank;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     armed;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], din_i};
        st_d.prev  = st_q.chain[STAGES-1];
        if (rearm_i) begin
            st_d.blank = CNT_W'(STAGES);
        end else if (st_q.blank != '0) begin
            st_d.blank = st_q.blank - 1'b1;
        end
        armed  = (st_q.blank == '0) && !rearm_i;
        rise_o = armed &&  st_q.chain[STAGES-1] && !st_q.prev;
        fall_o = armed && !st_q.chain[STAGES-1] &&  st_q.prev;
    end

    // Blank one cycle beyond the chain depth after reset so that a pin
    // already high at release is not mistaken for a rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{chain: '0, prev: 1'b0, blank: CNT_W'(STAGES + 1)};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/evs_capture.sv
module evs_capture
    import evs_pkg::*;
#(
    parameter int SEC_W = 32,
    parameter int NS_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_i,
    input  logic                  edge_fall_i,
    input  logic                  rise_i,
    input  logic                  fall_i,
    input  logic                  rd_i,
    input  logic [SEC_W-1:0]      sec_i,
    input  logic [NS_W-1:0]       nsec_i,
    output logic [SEC_W+NS_W-1:0] stamp_o,
    output logic                  valid_o,
    output logic                  ovf_o
);

    localparam int STAMP_W = SEC_W + NS_W;

    typedef struct packed {
        logic [STAMP_W-1:0] stamp;
        logic               valid;
        logic               ovf;
    } cap_st_t;

    cap_st_t   cap_d, cap_q;
    edge_pol_e pol;
    logic      fire;

    always_comb begin
        pol   = edge_pol_e'(edge_fall_i);
        fire  = en_i && ((pol == EDGE_FALL) ? fall_i : rise_i);
        cap_d = cap_q;
        cap_d.valid = fire || (cap_q.valid && !rd_i);
        if (fire) begin
            cap_d.stamp = {sec_i, nsec_i};
            cap_d.ovf   = cap_q.valid && !rd_i;
        end else begin
            cap_d.ovf   = cap_q.ovf && !rd_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign stamp_o = cap_q.stamp;
    assign valid_o = cap_q.valid;
    assign ovf_o   = cap_q.ovf;

endmodule

// File: rtl/ext_event_stamp.sv
module ext_event_stamp #(
    parameter int  NUM_PINS    = 64,
    parameter int  SEC_W       = 32,
    parameter int  NS_W        = 32,
    parameter int  SYNC_STAGES = 2,
    localparam int SEL_W       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEC_W-1:0]      sec_i,
    input  logic [NS_W-1:0]       nsec_i,
    input  logic [NUM_PINS-1:0]   pins_i,
    input  logic                  cap_en_i,
    input  logic                  edge_fall_i,
    input  logic [SEL_W-1:0]      sel_i,
    input  logic                  rd_i,
    output logic [SEC_W+NS_W-1:0] stamp_o,
    output logic                  valid_o,
    output logic                  ovf_o
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } top_st_t;

    top_st_t top_d, top_q;
    logic    pin_sel;
    logic    rearm;
    logic    edge_rise;
    logic    edge_fall;

    always_comb begin
        top_d     = top_q;
        top_d.sel = sel_i;
        rearm     = (sel_i != top_q.sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    evs_pin_mux #(
        .NUM_PINS (NUM_PINS),
        .SEL_W    (SEL_W)
    ) i_pin_mux (
        .pins_i (pins_i),
        .sel_i  (sel_i),
        .pin_o  (pin_sel)
    );

    evs_sync_edge #(
        .STAGES (SYNC_STAGES)
    ) i_sync_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .din_i   (pin_sel),
        .rearm_i (rearm),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    evs_capture #(
        .SEC_W (SEC_W),
        .NS_W  (NS_W)
    ) i_capture (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (cap_en_i),
        .edge_fall_i (edge_fall_i),
        .rise_i      (edge_rise),
        .fall_i      (edge_fall),
        .rd_i        (rd_i),
        .sec_i       (sec_i),
        .nsec_i      (nsec_i),
        .stamp_o     (stamp_o),
        .valid_o     (valid_o),
        .ovf_o       (ovf_o)
    );

endmodule

// File: rtl/evs_checker.sv
module evs_checker #(
    parameter int SEL_W = 6,
    parameter int SEC_W = 32,
    parameter int NS_W  = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [SEC_W-1:0]      sec_i,
    input logic [NS_W-1:0]       nsec_i,
    input logic                  cap_en_i,
    input logic [SEL_W-1:0]      sel_i,
    input logic                  rd_i,
    input logic [SEC_W+NS_W-1:0] stamp_o,
    input logic                  valid_o,
    input logic                  ovf_o
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !ovf_o && stamp_o == '0)); // R1

    AST_FRESH_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (stamp_o == $past({sec_i, nsec_i}))); // R2

    AST_READ_DROPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> !ovf_o); // R6

    AST_OVF_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> valid_o); // R7

    AST_OVF_RISE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(valid_o)); // R7

    AST_OFF_HOLDS_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en_i |=> $stable(stamp_o)); // R8

    AST_SEL_SWITCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && (sel_i != $past(sel_i))) |=> !valid_o); // R9

endmodule

bind ext_event_stamp evs_checker #(
    .SEL_W (SEL_W),
    .SEC_W (SEC_W),
    .NS_W  (NS_W)
) i_evs_checker (.*);

// File: tb/test_ext_event_stamp.sv
module test_ext_event_stamp;

    localparam int CLK_PERIOD = 10;
    localparam int NPINS      = 64;
    localparam int SYNC       = 3;
    localparam int SELW       = $clog2(NPINS);
    localparam int WD_CYCLES  = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [31:0]      tsec = 32'h5EC0_0001;
    logic [31:0]      tns  = 32'd999_999_930;
    logic [NPINS-1:0] pins = '0;
    logic             en = 1'b1;
    logic             efall = 1'b0;
    logic [SELW-1:0]  sel = SELW'(5);
    logic             rd = 1'b0;
    logic [63:0]      stamp;
    logic             valid;
    logic             ovf;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running time source that steps 7 ns per cycle.
    always @(posedge clk) begin
        if (tns >= 32'd999_999_993) begin
            tns  <= 32'd0;
            tsec <= tsec + 1;
        end else begin
            tns  <= tns + 32'd7;
        end
    end

    ext_event_stamp #(
        .NUM_PINS    (NPINS),
        .SEC_W       (32),
        .NS_W        (32),
        .SYNC_STAGES (SYNC)
    ) i_ext_event_stamp (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_i       (tsec),
        .nsec_i      (tns),
        .pins_i      (pins),
        .cap_en_i    (en),
        .edge_fall_i (efall),
        .sel_i       (sel),
        .rd_i        (rd),
        .stamp_o     (stamp),
        .valid_o     (valid),
        .ovf_o       (ovf)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one pin, wait out the synchroniser, note the time presented in
    // the capturing cycle, optionally read in that same cycle.
    task automatic make_edge(input int idx, input logic lvl, input logic rd_same,
                             output logic [63:0] exp);
        @(negedge clk);
        pins[idx] = lvl;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        exp = {tsec, tns};
        rd  = rd_same;
        @(posedge clk);
        @(negedge clk);
        rd  = 1'b0;
    endtask

    task automatic do_read();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [63:0] unused;
        pins[5] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 stamp in reset", stamp, 64'd0);
        chk("R1 valid in reset", {63'd0, valid}, 64'd0);
        chk("R1 ovf in reset", {63'd0, ovf}, 64'd0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R10 high pin at release", {63'd0, valid}, 64'd0);
        chk("R1 stamp after release", stamp, 64'd0);
        unused = '0;
    endtask

    task automatic t_rise();
        logic [63:0] e;
        logic [63:0] held;
        make_edge(5, 1'b0, 1'b0, e);
        chk("R3 fall ignored in rise mode", {63'd0, valid}, 64'd0);
        make_edge(5, 1'b1, 1'b0, e);
        chk("R2 valid on rise", {63'd0, valid}, 64'd1);
        chk("R2 stamp on rise", stamp, e);
        chk("R4 seconds field", {32'd0, stamp[63:32]}, {32'd0, e[63:32]});
        chk("R4 nanoseconds field", {32'd0, stamp[31:0]}, {32'd0, e[31:0]});
        chk("R2 no ovf on first", {63'd0, ovf}, 64'd0);
        held = stamp;
        do_read();
        chk("R6 valid cleared by read", {63'd0, valid}, 64'd0);
        chk("R6 stamp kept by read", stamp, held);
    endtask

    task automatic t_fall();
        logic [63:0] e;
        logic [63:0] e2;
        @(negedge clk);
        efall = 1'b1;
        make_edge(5, 1'b0, 1'b0, e);
        chk("R3 fall captures", {63'd0, valid}, 64'd1);
        chk("R3 fall stamp", stamp, e);
        do_read();
        make_edge(5, 1'b1, 1'b0, e2);
        chk("R3 rise ignored in fall mode", {63'd0, valid}, 64'd0);
        chk("R3 stamp kept", stamp, e);
        @(negedge clk);
        efall = 1'b0;
    endtask

    task automatic t_select();
        logic [63:0] e;
        @(negedge clk);
        sel = SELW'(63);
        repeat (6) @(negedge clk);
        make_edge(62, 1'b1, 1'b0, e);
        chk("R5 other pin ignored", {63'd0, valid}, 64'd0);
        make_edge(63, 1'b1, 1'b0, e);
        chk("R5 pin 63 captures", stamp, e);
        do_read();
        @(negedge clk);
        sel = SELW'(0);
        repeat (6) @(negedge clk);
        make_edge(0, 1'b1, 1'b0, e);
        chk("R5 pin 0 captures", stamp, e);
        chk("R5 pin 0 valid", {63'd0, valid}, 64'd1);
        do_read();
    endtask

    task automatic t_overflow();
        logic [63:0] e1;
        logic [63:0] e2;
        logic [63:0] dummy;
        make_edge(0, 1'b0, 1'b0, dummy);
        make_edge(0, 1'b1, 1'b0, e1);
        chk("R7 first stamp", stamp, e1);
        make_edge(0, 1'b0, 1'b0, dummy);
        make_edge(0, 1'b1, 1'b0, e2);
        chk("R7 newer stamp wins", stamp, e2);
        chk("R7 ovf set", {63'd0, ovf}, 64'd1);
        chk("R7 valid still set", {63'd0, valid}, 64'd1);
        do_read();
        chk("R6 ovf cleared by read", {63'd0, ovf}, 64'd0);
        chk("R6 valid cleared after ovf", {63'd0, valid}, 64'd0);
    endtask

    task automatic t_disabled();
        logic [63:0] held;
        logic [63:0] dummy;
        held = stamp;
        @(negedge clk);
        en = 1'b0;
        make_edge(0, 1'b0, 1'b0, dummy);
        make_edge(0, 1'b1, 1'b0, dummy);
        chk("R8 no capture while off", {63'd0, valid}, 64'd0);
        chk("R8 stamp held while off", stamp, held);
        chk("R8 ovf unchanged while off", {63'd0, ovf}, 64'd0);
        @(negedge clk);
        en = 1'b1;
    endtask

    task automatic t_selchange();
        logic [63:0] e;
        logic [63:0] dummy;
        @(negedge clk);
        pins[10] = 1'b1;
        pins[11] = 1'b0;
        sel = SELW'(11);
        repeat (8) @(negedge clk);
        sel = SELW'(10);
        repeat (8) @(negedge clk);
        chk("R9 switch to high pin quiet", {63'd0, valid}, 64'd0);
        make_edge(10, 1'b0, 1'b0, dummy);
        make_edge(10, 1'b1, 1'b0, e);
        chk("R9 capture after blanking", stamp, e);
        do_read();
    endtask

    task automatic t_rd_same();
        logic [63:0] e1;
        logic [63:0] e2;
        logic [63:0] dummy;
        make_edge(10, 1'b0, 1'b0, dummy);
        make_edge(10, 1'b1, 1'b0, e1);
        chk("R11 first capture held", {63'd0, valid}, 64'd1);
        make_edge(10, 1'b0, 1'b0, dummy);
        make_edge(10, 1'b1, 1'b1, e2);
        chk("R11 new stamp stored", stamp, e2);
        chk("R11 valid stays", {63'd0, valid}, 64'd1);
        chk("R11 no ovf", {63'd0, ovf}, 64'd0);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog all requirements actual=%0d cycles expected<%0d", WD_CYCLES, WD_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_select();
        t_overflow();
        t_disabled();
        t_selchange();
        t_rd_same();
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule